// File: doc/BRIEF.md
# Spill-Receive Victim Placement Controller

This block keeps the tag and recency state of four private, 8-way set-associative last-level cache tiles and decides where every block goes when one core's request misses or hits away from home. Each tile carries a role bit: a Spiller tile runs a program that profits from more capacity, and a Receiver tile runs one that can lend space. Only blocks pushed out of a Spiller tile travel to a peer, and they may land only in a Receiver tile. Blocks pushed out of a Receiver tile, or out of a Spiller when no Receiver exists, simply leave the chip.

A core presents one request at a time: a read or an L1 writeback, with its core number and block address. The block answers after a latency set by where the block was found (own tile, peer tile or memory) and reports the tile involved, whether the displaced local block was spilled and to which tile, or dropped. A read that hits in a peer pulls the block home and frees the peer slot. A writeback merges into the block wherever it sits and allocates locally only when no copy exists. Data arrays, coherence messages and bus arbitration are not modelled.

Inside the chosen Receiver tile the slot is picked by ownership: an empty way first, otherwise the least recently used way whose block belongs to a Receiver core, and only if every block belongs to a Spiller core the plain LRU way.

Top module: `spill_place_ctl`

## Requirements
- R1: After reset every tile is empty, `req_ready_o` is 1, `resp_valid_o` is 0, and the first read of any address answers with kind 2.
- R2: A request matches only blocks whose owner equals `req_core_i` and whose tag (address bits above the set bits) and set (low address bits) agree; a read found in the requester's own tile answers kind 0 (local) with `resp_tile_o` equal to the requester, 7 cycles after acceptance.
- R3: A read found nowhere answers kind 2 (memory) 250 cycles after acceptance and installs the block in the requester's tile, so the next read of it is a local hit.
- R4: A read found in a peer tile answers kind 1 (remote) with `resp_tile_o` naming that peer, 50 cycles after acceptance; the block is removed from the peer and installed in the requester's tile.
- R5: A local install fills the lowest-numbered empty way of the set; in a full set it replaces the least recently used way, where every hit, install and merge makes the touched way most recent.
- R6: When a local install in a Spiller tile (role bit 1) displaces a valid block and some tile has role bit 0, the response carries `resp_spill_o`=1 and `resp_spill_tile_o` naming a role-0 tile, and the block is afterwards found there by its owner.
- R7: A valid block displaced by an install in a Receiver tile (role bit 0) is never spilled: `resp_drop_o`=1, `resp_spill_o`=0, and a later read of it misses.
- R8: A valid block displaced in a Spiller tile while no tile has role bit 0 is dropped with `resp_drop_o`=1.
- R9: In the target tile the spilled block takes the lowest empty way, else the least recent way owned by a role-0 core, else the least recent way; it becomes the most recent way there, and the replaced block leaves the chip.
- R10: A writeback whose block is in the requester's tile answers kind 0 after 7 cycles and refreshes its recency.
- R11: A writeback whose block is in a peer tile answers kind 1 naming that tile after 50 cycles and leaves the block where it is.
- R12: A writeback whose block is nowhere on chip answers kind 3 (allocated) after 7 cycles and installs it locally, spilling or dropping the displaced block as for a read.
- R13: Between acceptance and response `req_ready_o` is 0 and any request presented is ignored; `resp_valid_o` is a one-cycle pulse after which `req_ready_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_i | input | TILES | Per-tile role, 1 = Spiller, 0 = Receiver; held stable while running |
| req_valid_i | input | 1 | Request present |
| req_wb_i | input | 1 | 1 = L1 writeback, 0 = read |
| req_core_i | input | log2(TILES) | Requesting core and home tile |
| req_addr_i | input | TAG_W+log2(SETS) | Block address, set in the low bits |
| req_ready_o | output | 1 | Idle and able to accept a request |
| resp_valid_o | output | 1 | One-cycle response pulse |
| resp_kind_o | output | 2 | 0 local, 1 remote, 2 memory, 3 allocated |
| resp_tile_o | output | log2(TILES) | Tile where the block was found or merged |
| resp_spill_o | output | 1 | Displaced local block was moved to a peer |
| resp_spill_tile_o | output | log2(TILES) | Tile that received the spilled block |
| resp_drop_o | output | 1 | Displaced local block left the chip |

## Verification
The bench keeps its own copy of all four tiles' tags, owners and recency and predicts kind, tile, spill, drop and latency for each request, adopting only the randomly chosen Receiver after checking that it is a Receiver. Directed sequences fill single sets to separate empty-way filling from LRU replacement, touch Receiver-owned blocks so that ownership and not recency decides the remote slot, and repeat writebacks to peer-held blocks to show they stay put. All-Receiver and all-Spiller role settings isolate the two drop cases, and random traffic under four mixed role settings concentrated on two sets exercises the chains of remote hits, spills and evictions.

// File: rtl/spill_place_ctl.sv
module spill_place_ctl #(
  parameter int TILES = 4,
  parameter int WAYS = 8,
  parameter int SETS = 4,
  parameter int TAG_W = 4,
  parameter int LAT_LOCAL = 7,
  parameter int LAT_REMOTE = 50,
  parameter int LAT_MEM = 250,
  localparam int ID_W = $clog2(TILES),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TILES-1:0]  role_i,
  input  logic              req_valid_i,
  input  logic              req_wb_i,
  input  logic [ID_W-1:0]   req_core_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [1:0]        resp_kind_o,
  output logic [ID_W-1:0]   resp_tile_o,
  output logic              resp_spill_o,
  output logic [ID_W-1:0]   resp_spill_tile_o,
  output logic              resp_drop_o
);
  localparam int CNT_W = $clog2(LAT_MEM + 1);

  logic             vld [TILES][SETS][WAYS];
  logic [ID_W-1:0]  own [TILES][SETS][WAYS];
  logic [TAG_W-1:0] tg  [TILES][SETS][WAYS];
  logic [WAY_W-1:0] age [TILES][SETS][WAYS];
  logic [7:0]       lfsr;
  logic             busy;
  logic [CNT_W-1:0] cnt;

  wire              accept = req_valid_i && !busy;
  wire [SET_W-1:0]  st  = req_addr_i[SET_W-1:0];
  wire [TAG_W-1:0]  tin = req_addr_i[ADDR_W-1:SET_W];
  wire [ID_W-1:0]   me  = req_core_i;

  logic hit;
  logic [ID_W-1:0]  ht;
  logic [WAY_W-1:0] hw;
  always_comb begin
    hit = 1'b0; ht = me; hw = '0;
    for (int t = 0; t < TILES; t++)
      for (int w = 0; w < WAYS; w++)
        if (vld[t][st][w] && own[t][st][w] == me && tg[t][st][w] == tin) begin
          hit = 1'b1; ht = ID_W'(t); hw = WAY_W'(w);
        end
  end

  wire hit_loc = hit && ht == me;
  wire hit_rem = hit && ht != me;
  wire install = req_wb_i ? !hit : !hit_loc;
  wire rd_rem  = !req_wb_i && hit_rem;

  logic [WAY_W-1:0] lv;
  logic             lv_inv;
  always_comb begin
    lv = '0; lv_inv = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (age[me][st][w] == WAY_W'(WAYS - 1)) lv = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[me][st][w]) begin lv = WAY_W'(w); lv_inv = 1'b1; end
  end

  logic [ID_W-1:0] dst;
  logic            dst_ok;
  int              tt;
  always_comb begin
    dst = '0; dst_ok = 1'b0; tt = 0;
    for (int i = TILES - 1; i >= 0; i--) begin
      tt = (int'(lfsr[ID_W-1:0]) + i) % TILES;
      if (!role_i[tt] && ID_W'(tt) != me) begin dst = ID_W'(tt); dst_ok = 1'b1; end
    end
  end

  wire victim = install && !lv_inv;
  wire spill  = victim && role_i[me] && dst_ok;
  wire drop   = victim && !spill;

  logic [WAY_W-1:0] rs, best;
  logic             rcv_seen, rv;
  always_comb begin
    rs = '0; best = '0; rcv_seen = 1'b0; rv = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (age[dst][st][w] == WAY_W'(WAYS - 1)) rs = WAY_W'(w);
    for (int w = 0; w < WAYS; w++) begin
      rv = vld[dst][st][w] && !(rd_rem && ht == dst && hw == WAY_W'(w));
      if (rv && !role_i[own[dst][st][w]] && (!rcv_seen || age[dst][st][w] > best)) begin
        rcv_seen = 1'b1; best = age[dst][st][w]; rs = WAY_W'(w);
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      rv = vld[dst][st][w] && !(rd_rem && ht == dst && hw == WAY_W'(w));
      if (!rv) rs = WAY_W'(w);
    end
  end

  wire [ID_W-1:0]  ta  = (req_wb_i && hit_rem) ? ht : me;
  wire [WAY_W-1:0] taw = install ? lv : hw;

  logic [1:0]       kind_n;
  logic [CNT_W-1:0] lat_n;
  always_comb begin
    if (hit_loc)      kind_n = 2'd0;
    else if (hit_rem) kind_n = 2'd1;
    else              kind_n = req_wb_i ? 2'd3 : 2'd2;
    case (kind_n)
      2'd1:    lat_n = CNT_W'(LAT_REMOTE);
      2'd2:    lat_n = CNT_W'(LAT_MEM);
      default: lat_n = CNT_W'(LAT_LOCAL);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < TILES; t++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) begin
            vld[t][s][w] <= 1'b0; own[t][s][w] <= '0;
            tg[t][s][w]  <= '0;   age[t][s][w] <= WAY_W'(w);
          end
      lfsr <= 8'h01; busy <= 1'b0; cnt <= '0;
      resp_kind_o <= '0; resp_tile_o <= '0; resp_spill_o <= 1'b0;
      resp_spill_tile_o <= '0; resp_drop_o <= 1'b0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (accept) begin
        for (int w = 0; w < WAYS; w++) begin
          if (age[ta][st][w] < age[ta][st][taw]) age[ta][st][w] <= age[ta][st][w] + 1'b1;
          if (spill && age[dst][st][w] < age[dst][st][rs]) age[dst][st][w] <= age[dst][st][w] + 1'b1;
        end
        age[ta][st][taw] <= '0;
        if (rd_rem) vld[ht][st][hw] <= 1'b0;
        if (spill) begin
          age[dst][st][rs] <= '0; vld[dst][st][rs] <= 1'b1;
          own[dst][st][rs] <= me; tg[dst][st][rs] <= tg[me][st][lv];
        end
        if (install) begin
          vld[me][st][lv] <= 1'b1; own[me][st][lv] <= me; tg[me][st][lv] <= tin;
        end
        busy <= 1'b1; cnt <= lat_n;
        resp_kind_o <= kind_n; resp_tile_o <= ht; resp_spill_o <= spill;
        resp_spill_tile_o <= spill ? dst : '0; resp_drop_o <= drop;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
    end
  end

  assign req_ready_o  = !busy;
  assign resp_valid_o = busy && cnt == '0;
endmodule

// File: rtl/spill_place_ctl_chk.sv
module spill_place_ctl_chk #(
  parameter int TILES = 4,
  parameter int LAT_LOCAL = 7,
  parameter int LAT_REMOTE = 50,
  parameter int LAT_MEM = 250,
  localparam int ID_W = $clog2(TILES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TILES-1:0] role_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [ID_W-1:0]  req_core_i,
  input logic             resp_valid_o,
  input logic [1:0]       resp_kind_o,
  input logic [ID_W-1:0]  resp_tile_o,
  input logic             resp_spill_o,
  input logic [ID_W-1:0]  resp_spill_tile_o,
  input logic             resp_drop_o
);
  logic [ID_W-1:0] cur;
  logic            pend;
  int              waitc;
  int              lat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0; pend <= 1'b0; waitc <= 0;
    end else if (req_valid_i && req_ready_o) begin
      cur <= req_core_i; pend <= 1'b1; waitc <= 0;
    end else if (pend) begin
      waitc <= waitc + 1;
      if (resp_valid_o) pend <= 1'b0;
    end
  end

  always_comb begin
    case (resp_kind_o)
      2'd1:    lat_exp = LAT_REMOTE;
      2'd2:    lat_exp = LAT_MEM;
      default: lat_exp = LAT_LOCAL;
    endcase
  end

  // R13
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |=> !resp_valid_o && req_ready_o);
  // R13
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R13
  resp_has_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> pend);
  // R2 R3 R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> waitc == lat_exp);
  // R2
  local_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_kind_o == 2'd0) |-> resp_tile_o == cur);
  // R4
  remote_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_kind_o == 2'd1) |-> resp_tile_o != cur);
  // R6
  spill_roles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_spill_o) |-> role_i[cur] && !role_i[resp_spill_tile_o] && !resp_drop_o);
  // R8
  spiller_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_drop_o && role_i[cur]) |-> &role_i);
endmodule

bind spill_place_ctl spill_place_ctl_chk #(
  .TILES(TILES), .LAT_LOCAL(LAT_LOCAL), .LAT_REMOTE(LAT_REMOTE), .LAT_MEM(LAT_MEM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .role_i(role_i), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_core_i(req_core_i), .resp_valid_o(resp_valid_o),
  .resp_kind_o(resp_kind_o), .resp_tile_o(resp_tile_o), .resp_spill_o(resp_spill_o),
  .resp_spill_tile_o(resp_spill_tile_o), .resp_drop_o(resp_drop_o)
);

// File: tb/spill_place_ctl_bench.sv
module spill_place_ctl_bench;
  localparam int T = 4, S = 4, W = 8;

  logic       clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [3:0] role = 4'b0;
  logic       req_valid = 1'b0, req_wb = 1'b0;
  logic [1:0] req_core = '0;
  logic [5:0] req_addr = '0;
  logic       req_ready, resp_valid, resp_spill, resp_drop;
  logic [1:0] resp_kind, resp_tile, resp_spill_tile;

  spill_place_ctl u_spill_place_ctl (
    .clk(clk), .rst_n(rst_n), .role_i(role), .req_valid_i(req_valid), .req_wb_i(req_wb),
    .req_core_i(req_core), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .resp_valid_o(resp_valid), .resp_kind_o(resp_kind), .resp_tile_o(resp_tile),
    .resp_spill_o(resp_spill), .resp_spill_tile_o(resp_spill_tile), .resp_drop_o(resp_drop)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit mv [T][S][W];
  int mo [T][S][W];
  int mt [T][S][W];
  int ma [T][S][W];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string lbl, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", lbl, what, act, exp);
    end
  endtask

  task automatic mtouch(input int t, input int s, input int w);
    int o = ma[t][s][w];
    for (int i = 0; i < W; i++) if (ma[t][s][i] < o) ma[t][s][i]++;
    ma[t][s][w] = 0;
  endtask

  function automatic int lru(input int t, input int s);
    int r = 0;
    for (int i = 0; i < W; i++) if (ma[t][s][i] == W - 1) r = i;
    return r;
  endfunction

  function automatic int rslot(input int d, input int s);
    int r = lru(d, s);
    int best = -1;
    for (int i = 0; i < W; i++)
      if (mv[d][s][i] && role[mo[d][s][i]] == 1'b0 && ma[d][s][i] > best) begin
        best = ma[d][s][i]; r = i;
      end
    for (int i = W - 1; i >= 0; i--) if (!mv[d][s][i]) r = i;
    return r;
  endfunction

  task automatic do_reset(input logic [3:0] r);
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; role = r;
    for (int t = 0; t < T; t++)
      for (int s = 0; s < S; s++)
        for (int w = 0; w < W; w++) begin
          mv[t][s][w] = 1'b0; mo[t][s][w] = 0; mt[t][s][w] = 0; ma[t][s][w] = w;
        end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic xact(input string lbl, input int c, input int a, input bit wb, input bit spam);
    int s = a % S, tg = a / S, ht = -1, hw = -1, ek = 0, et = c, lat, lw, vo = 0, vt = 0, n, d, sl;
    bit inst = 1'b0, vv = 1'b0, esp = 1'b0, edr = 1'b0, anyr = 1'b0;
    for (int t = 0; t < T; t++)
      for (int w = 0; w < W; w++)
        if (mv[t][s][w] && mo[t][s][w] == c && mt[t][s][w] == tg) begin ht = t; hw = w; end
    if (ht == c) begin ek = 0; et = c; mtouch(c, s, hw); end
    else if (ht >= 0) begin
      ek = 1; et = ht;
      if (wb) mtouch(ht, s, hw);
      else begin mv[ht][s][hw] = 1'b0; inst = 1'b1; end
    end else begin ek = wb ? 3 : 2; et = c; inst = 1'b1; end
    if (inst) begin
      lw = lru(c, s);
      for (int i = W - 1; i >= 0; i--) if (!mv[c][s][i]) lw = i;
      vv = mv[c][s][lw]; vo = mo[c][s][lw]; vt = mt[c][s][lw];
      mv[c][s][lw] = 1'b1; mo[c][s][lw] = c; mt[c][s][lw] = tg;
      mtouch(c, s, lw);
      for (int t = 0; t < T; t++) if (t != c && role[t] == 1'b0) anyr = 1'b1;
      esp = vv && role[c] && anyr;
      edr = vv && !esp;
    end
    lat = (ek == 1) ? 50 : (ek == 2) ? 250 : 7;

    @(negedge clk);
    req_valid = 1'b1; req_core = 2'(c); req_addr = 6'(a); req_wb = wb;
    @(posedge clk);
    @(negedge clk);
    if (spam) req_addr = 6'(a ^ 6'h3c);
    else req_valid = 1'b0;
    n = 0;
    while (!resp_valid) begin
      if (spam) chk("R13", "ready while busy", int'(req_ready), 0);
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(lbl, "kind", int'(resp_kind), ek);
    chk(lbl, "tile", int'(resp_tile), et);
    chk(lbl, "latency", n, lat);
    chk(lbl, "spill", int'(resp_spill), int'(esp));
    chk(lbl, "drop", int'(resp_drop), int'(edr));
    if (esp && resp_spill) begin
      d = int'(resp_spill_tile);
      chk("R6", "spill target is a Receiver peer", int'(role[d] == 1'b0 && d != c), 1);
      if (role[d] == 1'b0 && d != c) begin
        sl = rslot(d, s);
        mv[d][s][sl] = 1'b1; mo[d][s][sl] = vo; mt[d][s][sl] = vt;
        mtouch(d, s, sl);
      end
    end
    @(negedge clk);
    chk("R13", "pulse ended and ready", int'(!resp_valid && req_ready), 1);
  endtask

  initial begin
    do_reset(4'b1101);
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "no response after reset", int'(resp_valid), 0);
    xact("R1", 0, 0, 1'b0, 1'b0);
    for (int t = 1; t < 8; t++) xact("R3", 0, t * 4, 1'b0, 1'b0);
    xact("R2", 0, 0, 1'b0, 1'b0);
    xact("R2", 1, 0, 1'b0, 1'b0);
    xact("R5", 0, 32, 1'b0, 1'b0);
    xact("R5", 0, 4, 1'b0, 1'b0);
    xact("R4", 0, 4, 1'b0, 1'b0);
    xact("R10", 0, 0, 1'b1, 1'b0);
    xact("R11", 0, 8, 1'b1, 1'b0);
    xact("R11", 0, 8, 1'b1, 1'b0);
    xact("R12", 0, 60, 1'b1, 1'b0);
    for (int t = 0; t < 8; t++) xact("R9", 1, t * 4 + 1, 1'b0, 1'b0);
    for (int t = 0; t < 12; t++) xact("R9", 0, t * 4 + 1, 1'b0, 1'b0);
    for (int t = 4; t < 8; t++) xact("R9", 1, t * 4 + 1, 1'b0, 1'b0);
    for (int t = 0; t < 10; t++) xact("R9", 2, t * 4 + 1, 1'b0, 1'b0);
    xact("R9", 0, 1, 1'b0, 1'b0);
    xact("R9", 1, 17, 1'b0, 1'b0);
    xact("R13", 3, 2, 1'b0, 1'b1);
    xact("R13", 3, 2 ^ 6'h3c, 1'b0, 1'b0);

    do_reset(4'b0000);
    for (int t = 0; t < 9; t++) xact("R7", 2, t * 4 + 2, 1'b0, 1'b0);
    xact("R7", 2, 2, 1'b0, 1'b0);

    do_reset(4'b1111);
    for (int t = 0; t < 9; t++) xact("R8", 3, t * 4 + 3, 1'b0, 1'b0);
    xact("R8", 3, 3, 1'b0, 1'b0);

    foreach (cfgs[k]) begin
      do_reset(cfgs[k]);
      for (int i = 0; i < 100; i++)
        xact("R6", int'($urandom % 4), int'(($urandom % 16) * 4 + ($urandom % 2)),
             ($urandom % 8) == 0, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [3:0] cfgs [4] = '{4'b0001, 4'b0101, 4'b0110, 4'b1101};
endmodule